// File: doc/BRIEF.md
# Overlapping 1011 Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on every rising clock edge, and flags each place where the four most recent bits, oldest first, read 1, 0, 1, 1. Matches may overlap. The last 1 of a hit is kept as the first 1 of the next candidate, so the stream 1011011 produces two hits.

Two flags are produced.

- **Mealy flag:** combinational. It rises during the cycle in which the final 1 is present on the input, ahead of the edge that samples it.
- **Moore flag:** comes straight from a decoded state register. It rises for one cycle after that edge and carries no combinational path from the input.

Each flag is produced by its own small state machine. The Mealy machine has four states. The Moore machine has five, because it needs an extra state for a completed match.

An elaboration parameter selects how the states are coded in the flops: binary, Gray or Johnson. The choice does not change what the block does at its ports. An active-high asynchronous reset returns both machines to their idle state at once.

Top module: `pat1011_detector`

## Requirements
- R1: Asserting `rst` (active high, asynchronous) forces both machines to idle with no clock edge, so both `hit_mealy` and `hit_moore` read 0 even with `din` = 1. After reset is released, bits seen before the reset never contribute to a match.
- R2: `din` is sampled on each rising edge of `clk`. A match is the four most recent sampled bits forming 1, 0, 1, 1 in arrival order, with the oldest bit first.
- R3: `hit_mealy` is 1 exactly when the last three sampled bits are 1, 0, 1 and the present value of `din` is 1. It follows `din` combinationally within the cycle.
- R4: `hit_moore` is 1 for exactly the one cycle that follows the rising edge that sampled the final 1 of a match. It depends only on the registered state.
- R5: Detection does not restart after a hit. The stream 1011011 gives two hits on each flag, and 10111011 gives hits after its fourth and eighth bits.
- R6: `hit_moore` is never 1 in two consecutive cycles, because overlapping matches are at least three bits apart.
- R7: Streams that do not contain the pattern raise neither flag. Examples are 1001, 111, 1010 and all zeros. A 0 that follows a sampled 1, 0 discards the partial match.
- R8: The parameter `ENC_STYLE` (binary, Gray or Johnson) gives identical `hit_mealy` and `hit_moore` sequences for any input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Asynchronous active-high reset to idle |
| din | input | 1 | Serial data bit |
| hit_mealy | output | 1 | Combinational match flag, valid before the edge that takes the final 1 |
| hit_moore | output | 1 | Registered-state match flag, high the cycle after that edge |

## Verification
The Mealy flag belongs to the cycle in which the final 1 is on `din`, before the edge that samples it. The bench therefore drives `din` at the falling edge and compares `hit_mealy` one nanosecond later against a model built from the bits sampled so far plus the live bit. The Moore flag is due one edge later. It is compared one nanosecond after the rising edge, once the model has shifted in the bit just sampled. Three instances, one per encoding, are compared against the same model on every cycle. A reset applied between edges is checked before any further edge arrives.

// File: rtl/pat1011_pkg.sv
`timescale 1ns/1ps
package pat1011_pkg;

    typedef enum logic [1:0] {
        ENC_BINARY  = 2'd0,
        ENC_GRAY    = 2'd1,
        ENC_JOHNSON = 2'd2
    } enc_style_e;

    // Logical progress through the pattern; PH_MATCH is used by the Moore path only.
    typedef enum logic [2:0] {
        PH_IDLE         = 3'd0,
        PH_ONE          = 3'd1,
        PH_ONE_ZERO     = 3'd2,
        PH_ONE_ZERO_ONE = 3'd3,
        PH_MATCH        = 3'd4
    } phase_e;

    localparam int NUM_PHASES = 5;
    localparam int CODE_W     = 3;

    // Flop code for a logical phase under a given style.
    function automatic logic [CODE_W-1:0] phase_code(enc_style_e style, phase_e ph);
        logic [CODE_W-1:0] idx;
        logic [CODE_W-1:0] v;
        idx = CODE_W'(ph);
        v   = '0;
        case (style)
            ENC_GRAY: v = idx ^ (idx >> 1);
            ENC_JOHNSON: begin
                for (int k = 0; k < NUM_PHASES; k++) begin
                    if (k < int'(ph)) v = {v[CODE_W-2:0], ~v[CODE_W-1]};
                end
            end
            default: v = idx;
        endcase
        return v;
    endfunction

    // Transition function; with_match selects the five-phase Moore variant.
    function automatic phase_e phase_step(phase_e ph, logic b_in, logic with_match);
        phase_e nx;
        case (ph)
            PH_IDLE:         nx = b_in ? PH_ONE : PH_IDLE;
            PH_ONE:          nx = b_in ? PH_ONE : PH_ONE_ZERO;
            PH_ONE_ZERO:     nx = b_in ? PH_ONE_ZERO_ONE : PH_IDLE;
            PH_ONE_ZERO_ONE: nx = b_in ? (with_match ? PH_MATCH : PH_ONE) : PH_ONE_ZERO;
            PH_MATCH:        nx = b_in ? PH_ONE : PH_ONE_ZERO;
            default:         nx = PH_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/pat1011_state_reg.sv
`timescale 1ns/1ps
module pat1011_state_reg
    import pat1011_pkg::*;
#(
    parameter enc_style_e ENC_STYLE = ENC_BINARY
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e next_ph,
    output phase_e cur_ph
);

    localparam logic [CODE_W-1:0] IDLE_CODE = phase_code(ENC_STYLE, PH_IDLE);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            code_q <= IDLE_CODE;
        end else begin
            code_q <= phase_code(ENC_STYLE, next_ph);
        end
    end

    // Decode back to the logical phase; unused codes fall to idle.
    always_comb begin
        cur_ph = PH_IDLE;
        for (int k = 0; k < NUM_PHASES; k++) begin
            if (code_q == phase_code(ENC_STYLE, phase_e'(k))) cur_ph = phase_e'(k);
        end
    end

endmodule

// File: rtl/pat1011_track.sv
`timescale 1ns/1ps
module pat1011_track
    import pat1011_pkg::*;
#(
    parameter enc_style_e ENC_STYLE  = ENC_BINARY,
    parameter bit         WITH_MATCH = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   din,
    output phase_e ph
);

    phase_e nx_ph;

    always_comb nx_ph = phase_step(ph, din, WITH_MATCH);

    pat1011_state_reg #(
        .ENC_STYLE (ENC_STYLE)
    ) state_i (
        .clk     (clk),
        .rst     (rst),
        .next_ph (nx_ph),
        .cur_ph  (ph)
    );

endmodule

// File: rtl/pat1011_detector.sv
`timescale 1ns/1ps
module pat1011_detector
    import pat1011_pkg::*;
#(
    parameter enc_style_e ENC_STYLE = ENC_BINARY
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit_mealy,
    output logic hit_moore
);

    phase_e mealy_ph;
    phase_e moore_ph;

    // Four-phase machine: output lives on the transition.
    pat1011_track #(
        .ENC_STYLE  (ENC_STYLE),
        .WITH_MATCH (1'b0)
    ) mealy_i (
        .clk (clk),
        .rst (rst),
        .din (din),
        .ph  (mealy_ph)
    );

    // Five-phase machine: output lives on the match phase.
    pat1011_track #(
        .ENC_STYLE  (ENC_STYLE),
        .WITH_MATCH (1'b1)
    ) moore_i (
        .clk (clk),
        .rst (rst),
        .din (din),
        .ph  (moore_ph)
    );

    assign hit_mealy = (mealy_ph == PH_ONE_ZERO_ONE) && din;
    assign hit_moore = (moore_ph == PH_MATCH);

endmodule

// File: rtl/pat1011_detector_chk.sv
`timescale 1ns/1ps
module pat1011_detector_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic hit_mealy,
    input logic hit_moore
);

    logic       armed;
    logic [1:0] depth;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            armed <= 1'b0;
            depth <= 2'd0;
        end else begin
            armed <= 1'b1;
            if (depth != 2'd3) depth <= depth + 2'd1;
        end
    end

    // R1: during reset both flags stay low
    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (!hit_mealy && !hit_moore);
        end
    end

    // R3: the Mealy flag requires a live 1 on the input
    assert_mealy_needs_one_R3: assert property (@(posedge clk) disable iff (rst)
        hit_mealy |-> din);

    // R2: a Mealy hit is preceded by sampled 1, 0, 1
    assert_mealy_history_R2: assert property (@(posedge clk) disable iff (rst)
        (depth == 2'd3 && hit_mealy) |-> ($past(din, 1) && !$past(din, 2) && $past(din, 3)));

    // R4: the Moore flag trails the Mealy flag by exactly one edge
    assert_moore_follows_R4: assert property (@(posedge clk) disable iff (rst)
        armed |-> (hit_moore == $past(hit_mealy)));

    // R6: no back-to-back Moore hits
    assert_moore_single_R6: assert property (@(posedge clk) disable iff (rst)
        hit_moore |=> !hit_moore);

endmodule

bind pat1011_detector pat1011_detector_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .hit_mealy (hit_mealy),
    .hit_moore (hit_moore)
);

// File: tb/pat1011_detector_tb_top.sv
`timescale 1ns/1ps
module pat1011_detector_tb_top;
    import pat1011_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] hm;
    logic [2:0] ho;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;
    int  moore_hits = 0;
    bit  hist[$];
    logic prev_moore = 1'b0;

    always #2 clk = ~clk;

    pat1011_detector #(.ENC_STYLE(ENC_BINARY)) dut_i (
        .clk(clk), .rst(rst), .din(din), .hit_mealy(hm[0]), .hit_moore(ho[0]));
    pat1011_detector #(.ENC_STYLE(ENC_GRAY)) dut_gray_i (
        .clk(clk), .rst(rst), .din(din), .hit_mealy(hm[1]), .hit_moore(ho[1]));
    pat1011_detector #(.ENC_STYLE(ENC_JOHNSON)) dut_john_i (
        .clk(clk), .rst(rst), .din(din), .hit_mealy(hm[2]), .hit_moore(ho[2]));

    task automatic chk(input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input logic [2:0] act, input logic exp, input string what);
        chk(act[0], exp, {what, " binary"});
        chk(act[1], exp, {what, " gray R8"});
        chk(act[2], exp, {what, " johnson R8"});
    endtask

    task automatic step(input logic b, input string tag);
        logic exp_m;
        logic exp_o;
        int   n;
        @(negedge clk);
        din = b;
        #1;
        n = hist.size();
        exp_m = (n >= 3) && hist[n-3] && !hist[n-2] && hist[n-1] && b;
        cmp_all(hm, exp_m, {tag, " R3 mealy"});
        @(posedge clk);
        #1;
        hist.push_back(b);
        if (hist.size() > 4) void'(hist.pop_front());
        exp_o = (hist.size() == 4) && hist[0] && !hist[1] && hist[2] && hist[3];
        cmp_all(ho, exp_o, {tag, " R4 moore"});
        if (prev_moore && ho[0]) chk(1'b1, 1'b0, "R6 consecutive moore");
        prev_moore = ho[0];
        if (ho[0]) moore_hits++;
    endtask

    task automatic run_bits(input string bits, input string tag);
        for (int i = 0; i < bits.len(); i++) step(bits[i] == "1", tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int h;
        // R1 reset state
        din = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        cmp_all(hm, 1'b0, "R1 reset mealy");
        cmp_all(ho, 1'b0, "R1 reset moore");
        @(negedge clk);
        rst = 1'b0;

        // R2 single pattern
        moore_hits = 0;
        run_bits("001011000", "R2");
        chk(moore_hits == 1, 1'b1, "R2 one hit count");

        // R5 overlap
        moore_hits = 0;
        run_bits("1011011", "R5");
        chk(moore_hits == 2, 1'b1, "R5 overlap 1011011 count");
        moore_hits = 0;
        run_bits("010111011", "R5");
        chk(moore_hits == 2, 1'b1, "R5 overlap 10111011 count");

        // R7 non-matching streams
        moore_hits = 0;
        run_bits("0000100111101001101000", "R7");
        chk(moore_hits == 0, 1'b0 == 1'b0 ? 1'b1 : 1'b0, "R7 no hit count");

        // R1 asynchronous reset mid-pattern, no clock edge in between
        run_bits("101", "R1");
        @(negedge clk);
        din = 1'b1;
        #0.5;
        rst = 1'b1;
        #0.5;
        chk(hm[0], 1'b0, "R1 async mealy binary");
        chk(hm[1], 1'b0, "R1 async mealy gray R8");
        chk(hm[2], 1'b0, "R1 async mealy johnson R8");
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist.delete();
        prev_moore = 1'b0;
        moore_hits = 0;
        run_bits("1100", "R1");
        chk(moore_hits == 0, 1'b1, "R1 history cleared");

        // Random streams, all requirements via the model
        for (int c = 0; c < 4000; c++) begin
            h = $urandom_range(0, 3);
            step(h != 0 && (h != 1 || c[0]), "R2 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule